// File: doc/BRIEF.md
# Remote Update Configuration Sequencer

This block chooses which configuration image a device loads from a paged external image store, and watches each application image while it runs. Page 0 always holds a fixed recovery ("factory") image. After power-on in remote mode the factory image loads first. It then programs a control word that names the application page to load next, along with the watchdog settings for that application. Any failed application load, any watchdog expiry or any reconfiguration request from the application hands control back to the factory image. A two-bit status register records why that happened.

In local mode there is no factory stage. A single application page loads straight after power-on, and every recovery path reloads that same page. The image loader is modelled as a plain request / done / error handshake. The block drives a page number and holds a request level until the loader answers with a one-cycle done or error pulse.

The user watchdog runs only while an application image is running and the factory image has enabled it. A 12-bit timeout value is scaled by a 2^10-cycle prescaler, and each kick pulse from the application restarts the interval.

Top module: `cfg_image_sequencer`

## Requirements
- R1: In remote mode (`mode_local_i`=0), a power-on start pulse causes `load_req_o`=1 with `page_addr_o`=0 from the next cycle on.
- R2: In local mode (`mode_local_i`=1), a power-on start pulse requests page `LOCAL_PAGE` (default 1), so no page-0 load takes place. Every later recovery in local mode also requests page `LOCAL_PAGE`.
- R3: While a load is pending, `load_req_o` stays 1 and `page_addr_o` stays stable until `ld_done_i` or `ld_err_i` arrives. One cycle after `ld_done_i`, `load_req_o` is 0 and `page_addr_o` still shows the loaded page.
- R4: While the factory image runs, a control write with a page from 1 to 7 requests that page on the next cycle and captures the watchdog enable and timeout. Control writes made while an application runs are ignored.
- R5: A load error on an application page sets `status_o` to 2'b01 and requests page 0 on the next cycle.
- R6: With the watchdog enabled and timeout T, an application that is never kicked sees `load_req_o` rise for page 0 exactly (T+1)*1024 cycles after its load completes, and `status_o` becomes 2'b10.
- R7: A `kick_i` pulse restarts the full (T+1)*1024-cycle interval.
- R8: The watchdog never expires while the factory image runs, or while an application runs with its enable bit cleared.
- R9: `user_reconf_i` while an application runs sets `status_o` to 2'b11 and requests the recovery page. The same input is ignored while the factory image runs.
- R10: A factory control write that names page 0 sets `status_o` to 2'b01 and reloads page 0.
- R11: `status_o` keeps its value until `status_ack_i` arrives while the factory image runs, which clears it to 2'b00. An acknowledge is ignored while an application runs. A new cause that arrives in the same cycle as an acknowledge wins.
- R12: A load error while the factory image itself is loading retries page 0 and leaves `status_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_local_i | input | 1 | 1 = local update mode, 0 = remote update mode |
| por_start_i | input | 1 | Power-on start pulse |
| ld_done_i | input | 1 | Loader reports the requested page loaded |
| ld_err_i | input | 1 | Loader reports a failed load |
| kick_i | input | 1 | Watchdog restart pulse from the application |
| user_reconf_i | input | 1 | Application asks to return to recovery |
| ctrl_we_i | input | 1 | Factory control-word write strobe |
| ctrl_page_i | input | 3 | Next application page |
| ctrl_wd_en_i | input | 1 | Watchdog enable for the next application |
| ctrl_tmo_i | input | 12 | Watchdog timeout in units of 1024 cycles, minus one |
| status_ack_i | input | 1 | Factory acknowledge that clears the status |
| load_req_o | output | 1 | Load request level to the loader |
| page_addr_o | output | 3 | Page being loaded or running |
| status_o | output | 2 | Reconfiguration cause: 00 none, 01 load error, 10 timeout, 11 user request |

## Verification
The main path is tried with a table of factory control words. The table covers several valid pages that load and are then left by user request, pages whose load fails, and a page-0 write. This separates the three ways back to the factory image by the status code each one leaves. The watchdog is run unkicked, kicked midway and disabled, so an exact expiry cycle can be told apart from one that is early, late or missing. Acknowledges are given both in the factory image and in an application, and once in the same cycle as a new cause, to show when the status may clear. A local-mode run shows that no page-0 load takes place there.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_LOADERR = 2'b01,
    CAUSE_WDT     = 2'b10,
    CAUSE_USER    = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_LOAD = 2'b01,
    ST_RUN  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/cfgseq_status.sv
module cfgseq_status
  import cfgseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_i,
  input  cause_e cause_i,
  input  logic   clr_i,
  output cause_e cause_o
);
  cause_e cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (set_i)      cause_d = cause_i;
    else if (clr_i) cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= CAUSE_NONE;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  // R11: a new cause beats a simultaneous acknowledge
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> (cause_o == $past(cause_i)));
  // R11: without a cause or an acknowledge the status holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(cause_o));
endmodule

// File: rtl/cfgseq_watchdog.sv
module cfgseq_watchdog #(
  parameter int TMO_W = 12,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expire_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = &pre_q;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run_i || kick_i) begin
      pre_d = '0;
      cnt_d = tmo_i;
    end else begin
      pre_d = pre_q + 1'b1;
      if (tick && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i && !kick_i && tick && (cnt_q == '0);

  // R7: a kick restarts the whole interval
  a_r7_kick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && kick_i) |=> (cnt_q == $past(tmo_i) && pre_q == '0));
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
#(
  parameter int PAGE_W     = 3,
  parameter int TMO_W      = 12,
  parameter int LOCAL_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local_i,
  input  logic              por_start_i,
  input  logic              ld_done_i,
  input  logic              ld_err_i,
  input  logic              user_reconf_i,
  input  logic              status_ack_i,
  input  logic              ctrl_we_i,
  input  logic [PAGE_W-1:0] ctrl_page_i,
  input  logic              ctrl_wd_en_i,
  input  logic [TMO_W-1:0]  ctrl_tmo_i,
  input  logic              wd_expire_i,
  output logic              load_req_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              wd_run_o,
  output logic [TMO_W-1:0]  wd_tmo_o,
  output logic              st_set_o,
  output cause_e            st_cause_o,
  output logic              st_clr_o
);
  localparam logic [PAGE_W-1:0] LPAGE = PAGE_W'(LOCAL_PAGE);

  seq_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              wden_q, wden_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [PAGE_W-1:0] recov_page;
  logic              factory_run, app_run;

  assign recov_page  = mode_local_i ? LPAGE : '0;
  assign factory_run = (state_q == ST_RUN) && (page_q == '0) && !mode_local_i;
  assign app_run     = (state_q == ST_RUN) && !factory_run;

  always_comb begin
    state_d    = state_q;
    page_d     = page_q;
    wden_d     = wden_q;
    tmo_d      = tmo_q;
    st_set_o   = 1'b0;
    st_cause_o = CAUSE_NONE;
    unique case (state_q)
      ST_OFF: begin
        if (por_start_i) begin
          state_d = ST_LOAD;
          page_d  = recov_page;
        end
      end
      ST_LOAD: begin
        if (ld_err_i) begin
          page_d = recov_page;
          if (page_q != '0) begin
            st_set_o   = 1'b1;
            st_cause_o = CAUSE_LOADERR;
          end
        end else if (ld_done_i) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (factory_run && ctrl_we_i) begin
          state_d = ST_LOAD;
          wden_d  = ctrl_wd_en_i;
          tmo_d   = ctrl_tmo_i;
          page_d  = ctrl_page_i;
          if (ctrl_page_i == '0) begin
            st_set_o   = 1'b1;
            st_cause_o = CAUSE_LOADERR;
          end
        end else if (app_run && wd_expire_i) begin
          state_d    = ST_LOAD;
          page_d     = recov_page;
          st_set_o   = 1'b1;
          st_cause_o = CAUSE_WDT;
        end else if (app_run && user_reconf_i) begin
          state_d    = ST_LOAD;
          page_d     = recov_page;
          st_set_o   = 1'b1;
          st_cause_o = CAUSE_USER;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      page_q  <= '0;
      wden_q  <= 1'b0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      wden_q  <= wden_d;
      tmo_q   <= tmo_d;
    end
  end

  assign load_req_o = (state_q == ST_LOAD);
  assign page_o     = page_q;
  assign wd_run_o   = app_run && wden_q && !mode_local_i;
  assign wd_tmo_o   = tmo_q;
  assign st_clr_o   = factory_run && status_ack_i;

  // R1: remote power-on goes to page 0
  a_r1_factory_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && por_start_i && !mode_local_i) |=> (load_req_o && page_o == '0));
  // R2: local power-on goes straight to the application page
  a_r2_local_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && por_start_i && mode_local_i) |=> (load_req_o && page_o == LPAGE));
  // R3: a pending request holds until the loader answers
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && !ld_done_i && !ld_err_i) |=> (load_req_o && $stable(page_o)));
  // R5: a remote load error always falls back to page 0
  a_r5_err_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && ld_err_i && !mode_local_i) |=> (load_req_o && page_o == '0));
  // R10: page 0 named as an application reloads the factory image
  a_r10_page0_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (factory_run && ctrl_we_i && ctrl_page_i == '0) |=> (load_req_o && page_o == '0));
endmodule

// File: rtl/cfg_image_sequencer.sv
module cfg_image_sequencer
  import cfgseq_pkg::*;
#(
  parameter int PAGE_W     = 3,
  parameter int TMO_W      = 12,
  parameter int PRE_W      = 10,
  parameter int LOCAL_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_local_i,
  input  logic              por_start_i,
  input  logic              ld_done_i,
  input  logic              ld_err_i,
  input  logic              kick_i,
  input  logic              user_reconf_i,
  input  logic              ctrl_we_i,
  input  logic [PAGE_W-1:0] ctrl_page_i,
  input  logic              ctrl_wd_en_i,
  input  logic [TMO_W-1:0]  ctrl_tmo_i,
  input  logic              status_ack_i,
  output logic              load_req_o,
  output logic [PAGE_W-1:0] page_addr_o,
  output logic [1:0]        status_o
);
  logic             rst_meta_q, rst_sync_q;
  logic             wd_run, wd_expire;
  logic [TMO_W-1:0] wd_tmo;
  logic             st_set, st_clr;
  cause_e           st_cause, cause_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfgseq_ctrl #(
    .PAGE_W(PAGE_W), .TMO_W(TMO_W), .LOCAL_PAGE(LOCAL_PAGE)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .mode_local_i  (mode_local_i),
    .por_start_i   (por_start_i),
    .ld_done_i     (ld_done_i),
    .ld_err_i      (ld_err_i),
    .user_reconf_i (user_reconf_i),
    .status_ack_i  (status_ack_i),
    .ctrl_we_i     (ctrl_we_i),
    .ctrl_page_i   (ctrl_page_i),
    .ctrl_wd_en_i  (ctrl_wd_en_i),
    .ctrl_tmo_i    (ctrl_tmo_i),
    .wd_expire_i   (wd_expire),
    .load_req_o    (load_req_o),
    .page_o        (page_addr_o),
    .wd_run_o      (wd_run),
    .wd_tmo_o      (wd_tmo),
    .st_set_o      (st_set),
    .st_cause_o    (st_cause),
    .st_clr_o      (st_clr)
  );

  cfgseq_watchdog #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run_i    (wd_run),
    .kick_i   (kick_i),
    .tmo_i    (wd_tmo),
    .expire_o (wd_expire)
  );

  cfgseq_status u_status (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .set_i   (st_set),
    .cause_i (st_cause),
    .clr_i   (st_clr),
    .cause_o (cause_q)
  );

  assign status_o = cause_q;

  // R8: the watchdog cannot fire while page 0 is loaded or running
  a_r8_no_wd_factory: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!mode_local_i && page_addr_o == '0) |-> !wd_expire);
  // R6: an expiry always ends in a timeout cause and a page-0 request
  a_r6_expire_effect: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wd_expire |=> (load_req_o && page_addr_o == '0 && status_o == 2'b10));
endmodule

// File: tb/cfg_image_sequencer_tb_top.sv
module cfg_image_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_local, por_start, ld_done, ld_err, kick, user_reconf;
  logic        ctrl_we, ctrl_wd_en, status_ack;
  logic [2:0]  ctrl_page;
  logic [11:0] ctrl_tmo;
  logic        load_req;
  logic [2:0]  page_addr;
  logic [1:0]  status;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  cfg_image_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_local_i(mode_local), .por_start_i(por_start),
    .ld_done_i(ld_done), .ld_err_i(ld_err), .kick_i(kick), .user_reconf_i(user_reconf),
    .ctrl_we_i(ctrl_we), .ctrl_page_i(ctrl_page), .ctrl_wd_en_i(ctrl_wd_en),
    .ctrl_tmo_i(ctrl_tmo), .status_ack_i(status_ack), .load_req_o(load_req),
    .page_addr_o(page_addr), .status_o(status)
  );

  // vector: [5:3] page written by factory, [2] load fails, [1:0] expected cause
  localparam logic [5:0] VEC [6] = '{
    {3'd1, 1'b0, 2'b11}, {3'd7, 1'b0, 2'b11}, {3'd3, 1'b1, 2'b01},
    {3'd0, 1'b0, 2'b01}, {3'd5, 1'b1, 2'b01}, {3'd2, 1'b0, 2'b11}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic local_mode);
    rst_n = 1'b0; mode_local = local_mode; por_start = 0; ld_done = 0; ld_err = 0;
    kick = 0; user_reconf = 0; ctrl_we = 0; ctrl_wd_en = 0; status_ack = 0;
    ctrl_page = '0; ctrl_tmo = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic p_por;    por_start = 1;   tick(1); por_start = 0;   endtask
  task automatic p_done;   ld_done = 1;     tick(1); ld_done = 0;     endtask
  task automatic p_err;    ld_err = 1;      tick(1); ld_err = 0;      endtask
  task automatic p_user;   user_reconf = 1; tick(1); user_reconf = 0; endtask
  task automatic p_ack;    status_ack = 1;  tick(1); status_ack = 0;  endtask
  task automatic p_kick;   kick = 1;        tick(1); kick = 0;        endtask

  task automatic fw_write(input logic [2:0] pg, input logic en, input logic [11:0] t);
    ctrl_we = 1; ctrl_page = pg; ctrl_wd_en = en; ctrl_tmo = t;
    tick(1);
    ctrl_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual run unfinished expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    check("reset load_req", load_req, 0);
    check("reset status", status, 0);
    check("reset page", page_addr, 0);

    // R1 then the table of factory control words
    p_por;
    check("R1 req", load_req, 1);
    check("R1 page", page_addr, 0);
    p_done;
    for (int i = 0; i < 6; i++) begin
      logic [2:0] pg;
      logic       fl;
      logic [1:0] cs;
      pg = VEC[i][5:3]; fl = VEC[i][2]; cs = VEC[i][1:0];
      fw_write(pg, 1'b0, 12'd0);
      if (pg == 3'd0) begin
        check("R10 req", load_req, 1);
        check("R10 page", page_addr, 0);
        check("R10 status", status, cs);
      end else begin
        check("R4 req", load_req, 1);
        check("R4 page", page_addr, pg);
        if (fl) begin
          p_err;
          check("R5 req", load_req, 1);
          check("R5 page", page_addr, 0);
          check("R5 status", status, cs);
        end else begin
          p_done;
          check("R3 req drop", load_req, 0);
          check("R3 page kept", page_addr, pg);
          p_user;
          check("R9 req", load_req, 1);
          check("R9 page", page_addr, 0);
          check("R9 status", status, cs);
        end
      end
      p_done;
      p_ack;
      check("R11 ack clears", status, 0);
    end

    // R3 hold and R12 factory load error
    do_reset(1'b0);
    p_por;
    tick(5);
    check("R3 hold req", load_req, 1);
    check("R3 hold page", page_addr, 0);
    p_err;
    check("R12 retry req", load_req, 1);
    check("R12 retry page", page_addr, 0);
    check("R12 status", status, 0);
    p_done;
    check("R3 done drop", load_req, 0);
    p_user;
    check("R9 ignored in factory req", load_req, 0);
    check("R9 ignored in factory status", status, 0);

    // R6 exact expiry with T=2
    fw_write(3'd4, 1'b1, 12'd2);
    p_done;
    tick(3070);
    check("R6 before expiry", load_req, 0);
    tick(2);
    check("R6 expiry req", load_req, 1);
    check("R6 expiry page", page_addr, 0);
    check("R6 expiry status", status, 2'b10);
    p_done;
    tick(5000);
    check("R8 factory no timeout", load_req, 0);
    check("R11 status held", status, 2'b10);
    p_ack;
    check("R11 ack", status, 0);

    // R7 kick restarts, R4 writes ignored in application
    fw_write(3'd5, 1'b1, 12'd1);
    p_done;
    tick(2000);
    p_kick;
    tick(2000);
    check("R7 kicked still running", load_req, 0);
    fw_write(3'd3, 1'b0, 12'd0);
    check("R4 app write ignored req", load_req, 0);
    check("R4 app write ignored page", page_addr, 5);
    tick(60);
    check("R7 later expiry req", load_req, 1);
    check("R7 later expiry status", status, 2'b10);

    // R11 ack ignored in application, set wins over ack
    p_done;
    fw_write(3'd6, 1'b0, 12'd0);
    p_done;
    p_ack;
    check("R11 ack in app ignored", status, 2'b10);
    p_user;
    check("R9 user status", status, 2'b11);
    p_done;
    ctrl_we = 1; ctrl_page = 3'd0; ctrl_wd_en = 0; ctrl_tmo = '0; status_ack = 1;
    tick(1);
    ctrl_we = 0; status_ack = 0;
    check("R11 set wins", status, 2'b01);
    p_done;

    // R8 watchdog disabled for an application
    fw_write(3'd2, 1'b0, 12'd0);
    p_done;
    tick(5000);
    check("R8 disabled no timeout", load_req, 0);
    check("R8 disabled page", page_addr, 2);

    // R2 local mode
    do_reset(1'b1);
    p_por;
    check("R2 local req", load_req, 1);
    check("R2 local page", page_addr, 1);
    p_done;
    check("R2 local running", load_req, 0);
    p_user;
    check("R2 local recovery page", page_addr, 1);
    check("R2 local recovery status", status, 2'b11);
    p_err;
    check("R2 local err page", page_addr, 1);
    check("R5 local err status", status, 2'b01);
    p_done;
    check("R2 local done", load_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule